// File: doc/BRIEF.md
# Receive Interrupt Coalescing Unit

This block sits beside a receive frame queue and decides when the host should be interrupted. Instead of raising an interrupt for every arriving frame, it tracks three quantities: how long the oldest queued frame has been waiting, how many bytes are queued, and how many frames are queued. Each quantity has a programmable threshold and an enable. When any enabled quantity goes past its threshold, a single shared receive interrupt is raised.

The queue logic reports every frame that enters the queue and every frame the host removes, each with its byte length. The host acknowledges the interrupt with a one-cycle write-one-to-clear strobe. That strobe drops the interrupt and also captures which enabled conditions were true at that moment into three read-only cause flags. The flags hold their value until the next acknowledge.

Top module: `rx_irq_coalesce`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `irq`, `cause_time`, `cause_byte` and `cause_frame` are all 0 and every internal count is zero.
- R2: The frame count rises by one on each enqueue and falls by one on each dequeue. When `frame_en` is 1 and the count is strictly greater than `frame_thresh`, `irq` is set at the following clock edge.
- R3: The byte count rises by `enq_len` on each enqueue and falls by `deq_len` on each dequeue. When `byte_en` is 1 and the count is strictly greater than `byte_thresh`, `irq` is set at the following clock edge.
- R4: An elapsed-time count is 0 on the cycle after a frame enters an empty queue. It then increases by one per cycle while the queue is not empty and saturates at its maximum. When `time_en` is 1 and this count is strictly greater than `time_thresh`, `irq` is set at the following clock edge.
- R5: When the queue becomes empty, the elapsed-time count returns to 0. It does not run again until the next frame arrives.
- R6: A condition whose enable is 0 never sets `irq`. With all three enables at 0, `irq` stays 0 whatever the queue holds.
- R7: Once set, `irq` stays 1 until a cycle with `irq_ack` high, and the edge after that cycle clears it. If an enabled condition still holds after the clear, `irq` is set again at the next edge.
- R8: On the edge that samples `irq_ack` high, `cause_time`, `cause_byte` and `cause_frame` load the enabled time, byte and frame conditions as they stood on that cycle. At all other edges they keep their value.
- R9: An enqueue and a dequeue in the same cycle are netted. The frame count is unchanged and the byte count changes by `enq_len - deq_len`. A dequeue on an empty queue with no enqueue in the same cycle is ignored.
- R10: A threshold of 0 makes its condition true as soon as its count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | A frame entered the queue this cycle |
| enq_len | input | LEN_W | Byte length of the entering frame |
| deq_valid | input | 1 | The host removed a frame this cycle |
| deq_len | input | LEN_W | Byte length of the removed frame |
| time_thresh | input | TIME_W | Elapsed-time threshold, in cycles |
| byte_thresh | input | BYTE_W | Queued-byte threshold |
| frame_thresh | input | FRAME_W | Queued-frame threshold |
| time_en | input | 1 | Enable for the elapsed-time condition |
| byte_en | input | 1 | Enable for the byte condition |
| frame_en | input | 1 | Enable for the frame condition |
| irq_ack | input | 1 | Write-one-to-clear strobe for the interrupt |
| irq | output | 1 | Shared receive interrupt |
| cause_time | output | 1 | Captured elapsed-time cause |
| cause_byte | output | 1 | Captured byte cause |
| cause_frame | output | 1 | Captured frame cause |

## Verification
The bench targets the point where a count equals its threshold. A design that compares with greater-or-equal fires there one frame, one byte or one cycle early. It checks that the elapsed-time count starts fresh for each new burst: a timer that is not cleared when the queue drains fires at once on the next arrival. Acknowledges are issued while a condition still holds and while it does not, which exposes an interrupt that fails to re-assert and cause flags that track live conditions instead of latching at the acknowledge. Same-cycle enqueue and dequeue, and a dequeue on an empty queue, catch counters that drift or wrap.

// File: rtl/rx_irq_coalesce.sv
module rx_irq_coalesce #(
  parameter int TIME_W  = 16,
  parameter int BYTE_W  = 16,
  parameter int FRAME_W = 8,
  parameter int LEN_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enq_valid,
  input  logic [LEN_W-1:0]   enq_len,
  input  logic               deq_valid,
  input  logic [LEN_W-1:0]   deq_len,
  input  logic [TIME_W-1:0]  time_thresh,
  input  logic [BYTE_W-1:0]  byte_thresh,
  input  logic [FRAME_W-1:0] frame_thresh,
  input  logic               time_en,
  input  logic               byte_en,
  input  logic               frame_en,
  input  logic               irq_ack,
  output logic               irq,
  output logic               cause_time,
  output logic               cause_byte,
  output logic               cause_frame
);
  localparam logic [TIME_W-1:0]  TIME_MAX = '1;
  localparam logic [FRAME_W-1:0] ONE_F    = FRAME_W'(1);

  logic [TIME_W-1:0]  age_q;
  logic [BYTE_W-1:0]  bytes_q, bytes_nxt;
  logic [FRAME_W-1:0] frames_q, frames_nxt;
  logic               deq_ok;
  logic [2:0]         hit;

  assign deq_ok = deq_valid && (frames_q != '0 || enq_valid);

  assign frames_nxt = frames_q + (enq_valid ? ONE_F : '0) - (deq_ok ? ONE_F : '0);
  assign bytes_nxt  = bytes_q + (enq_valid ? BYTE_W'(enq_len) : '0)
                              - (deq_ok ? BYTE_W'(deq_len) : '0);

  assign hit = {time_en  && (age_q    > time_thresh),
                byte_en  && (bytes_q  > byte_thresh),
                frame_en && (frames_q > frame_thresh)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frames_q <= '0;
      bytes_q  <= '0;
      age_q    <= '0;
    end else begin
      frames_q <= frames_nxt;
      bytes_q  <= bytes_nxt;
      if (frames_nxt == '0 || frames_q == '0)
        age_q <= '0;
      else if (age_q != TIME_MAX)
        age_q <= age_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
      {cause_time, cause_byte, cause_frame} <= '0;
    end else begin
      irq <= irq_ack ? 1'b0 : (irq | (|hit));
      if (irq_ack)
        {cause_time, cause_byte, cause_frame} <= hit;
    end
  end

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_ack |=> irq);  // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq);  // R7
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_ack |=> $stable({cause_time, cause_byte, cause_frame}));  // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(time_en || byte_en || frame_en) && !irq |=> !irq);  // R6
  AST_AGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frames_q == '0 |-> age_q == '0);  // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid && !enq_valid && frames_q == '0 |=> frames_q == '0);  // R9
endmodule

// File: tb/tb_rx_irq_coalesce.sv
module tb_rx_irq_coalesce;
  logic clk = 0, rst_n = 0;
  logic enq_valid = 0, deq_valid = 0, irq_ack = 0;
  logic [10:0] enq_len = 0, deq_len = 0;
  logic [15:0] time_thresh = 0, byte_thresh = 0;
  logic [7:0]  frame_thresh = 0;
  logic time_en = 0, byte_en = 0, frame_en = 0;
  logic irq, cause_time, cause_byte, cause_frame;

  int vecs = 0, bad = 0;
  string tag = "R1";

  rx_irq_coalesce dut (.*);

  always #10 clk = ~clk;

  int m_fc, m_bc, m_tm, nf;
  bit m_irq;
  bit [2:0] m_cause, h;
  bit dok;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fc = 0; m_bc = 0; m_tm = 0; m_irq = 0; m_cause = 0;
    end else begin
      h = {time_en && m_tm > time_thresh, byte_en && m_bc > byte_thresh,
           frame_en && m_fc > frame_thresh};
      if (irq_ack) begin m_irq = 0; m_cause = h; end
      else if (h != 0) m_irq = 1;
      dok = deq_valid && (m_fc > 0 || enq_valid);
      nf = m_fc + int'(enq_valid) - int'(dok);
      m_bc = m_bc + (enq_valid ? int'(enq_len) : 0) - (dok ? int'(deq_len) : 0);
      if (nf == 0 || m_fc == 0) m_tm = 0;
      else if (m_tm < 65535) m_tm++;
      m_fc = nf;
    end
  end

  task automatic check();
    vecs++;
    if ({irq, cause_time, cause_byte, cause_frame} !== {m_irq, m_cause}) begin
      bad++;
      $display("FAIL %s: {irq,ct,cb,cf} actual %b expected %b", tag,
               {irq, cause_time, cause_byte, cause_frame}, {m_irq, m_cause});
    end
  endtask

  task automatic tick(bit e = 0, int el = 0, bit d = 0, int dl = 0, bit a = 0);
    enq_valid = e; enq_len = 11'(el); deq_valid = d; deq_len = 11'(dl); irq_ack = a;
    @(negedge clk);
    check();
    enq_valid = 0; deq_valid = 0; irq_ack = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic drain(int len);
    for (int i = 0; i < 8; i++) tick(0, 0, 1, len);
    tick(0, 0, 0, 0, 1);
    idle(2);
  endtask

  initial begin
    #(20ns * 200000);
    bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    @(negedge clk); check(); @(negedge clk); check();
    rst_n = 1;
    tick(); // R1 first cycle after reset

    tag = "R2"; frame_en = 1; frame_thresh = 2;
    tick(1, 64); tick(1, 64); idle(2);        // count == thresh: quiet
    tick(1, 64); idle(2);                      // exceeds
    tick(0, 0, 0, 0, 1); idle(2);              // R8 capture frame cause
    tag = "R7"; tick(0, 0, 0, 0, 1); idle(1);  // reassert while held
    drain(64); frame_en = 0;

    tag = "R3"; byte_en = 1; byte_thresh = 120;
    tick(1, 60); tick(1, 60); idle(2);         // 120 == thresh
    tick(1, 1); idle(2);
    tag = "R8"; tick(0, 0, 0, 0, 1); idle(2);
    tag = "R9"; tick(1, 10, 1, 60); tick(1, 5, 1, 61); idle(1);
    tick(0, 0, 0, 0, 1); idle(2);
    drain(10); byte_en = 0;
    tick(0, 0, 1, 50); idle(1);                // dequeue on empty ignored

    tag = "R4"; time_en = 1; time_thresh = 5;
    tick(1, 40); idle(3); tick(1, 40); idle(4);
    tick(0, 0, 0, 0, 1); idle(2);
    tag = "R5"; tick(0, 0, 1, 40); tick(0, 0, 1, 40); tick(0, 0, 0, 0, 1); idle(8);
    tick(1, 40); idle(3); tick(0, 0, 0, 0, 1); idle(4);
    drain(40);

    tag = "R10"; time_thresh = 0; tick(1, 20); idle(3);
    tick(0, 0, 0, 0, 1); idle(1); drain(20); time_en = 0;
    frame_thresh = 0; frame_en = 1; tick(1, 20); idle(2);
    tick(0, 0, 0, 0, 1); idle(1); drain(20); frame_en = 0;

    tag = "R6"; frame_thresh = 0; byte_thresh = 0; time_thresh = 0;
    for (int i = 0; i < 6; i++) tick(1, 100);
    idle(20); tick(0, 0, 0, 0, 1); idle(2);
    byte_en = 1; idle(2); tick(0, 0, 0, 0, 1); idle(2);
    byte_en = 0; drain(100);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule